// File: doc/BRIEF.md
# Rail-Clamping Gate Time Calculator

This block turns three signed per-phase times into three leg gating times for a three-leg inverter modulator that never applies a null vector. For each sample it finds the largest and smallest of the three phase times. It then works out a common time shift that parks one leg on a rail for the whole sampling period, and adds that shift to every phase. The phase times are the reference phase voltages scaled by the period over the DC bus voltage. The active interval, largest minus smallest, keeps its length but moves inside the period.

The rail is chosen by the sign of largest plus smallest. When that sum is zero or more, the largest leg is held high. When it is negative, the smallest leg is held low. As a result only two legs switch inside a period. Results are clipped to the range 0 to the period, so rounding or overmodulation can never yield an impossible gate time. Each result also reports which leg is parked and on which rail.

Samples enter on a valid/ready stream and leave on another, with a single output register stage between them. A sample is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. A result stays on the outputs, unchanged, for as long as `out_valid` is high and `out_ready` is low. Carrier comparison and reference generation lie outside this block.

Top module: `clamp_gate_timer`

## Requirements
- R1: When largest+smallest phase time is zero or more, the shift is period minus largest. The leg holding the largest time gets a gate time equal to the period and has its bit set in `clamp_hi` (bit 0 = leg a, bit 1 = leg b, bit 2 = leg c).
- R2: When largest+smallest is negative, the shift is minus smallest. The leg holding the smallest time gets gate time 0 and has its bit set in `clamp_lo`, using the same bit order.
- R3: A sum of exactly zero selects the high rail.
- R4: Every gate time equals its phase time plus the common shift, clipped to the range 0 to the period that was sampled with that input.
- R5: Each result has exactly one bit set across `clamp_hi` and `clamp_lo` together.
- R6: When several legs share the largest (or smallest) value, the flag marks the lowest-lettered of them.
- R7: `eff_time` equals largest minus smallest phase time, as an unsigned value.
- R8: A sample accepted at a clock edge appears on the outputs with `out_valid` high right after that edge. It is held stable while `out_valid` is high and `out_ready` is low.
- R9: During reset, `out_valid` is low.
- R10: `in_ready` is low while a result is held but not yet taken, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input sample can be taken |
| t_a | input | TW | Signed phase time, leg a |
| t_b | input | TW | Signed phase time, leg b |
| t_c | input | TW | Signed phase time, leg c |
| period | input | PW | Sampling period length, taken with the sample |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| g_a | output | PW | Gate time, leg a |
| g_b | output | PW | Gate time, leg b |
| g_c | output | PW | Gate time, leg c |
| eff_time | output | TW | Active interval length |
| clamp_hi | output | 3 | Leg parked on the high rail (one-hot or zero) |
| clamp_lo | output | 3 | Leg parked on the low rail (one-hot or zero) |

## Verification
Every result field appears on the outputs right after the edge that takes the sample, a latency of one cycle. The bench therefore drives a sample at a falling edge and compares all fields at the next falling edge, half a cycle after the register has loaded. Under back-pressure, the bench holds `out_ready` low across several cycles and reads the outputs at each falling edge to confirm nothing moves. It then releases `out_ready` together with a waiting sample and expects the new result one edge later.

// File: rtl/cgt_pkg.sv
package cgt_pkg;
  localparam int LEGS = 3;
  typedef logic [LEGS-1:0] leg_mask_t;
endpackage

// File: rtl/cgt_extremes.sv
module cgt_extremes
  import cgt_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic signed [TW-1:0] t_in [LEGS],
  output logic signed [TW-1:0] t_max,
  output logic signed [TW-1:0] t_min,
  output leg_mask_t            max_mask,
  output leg_mask_t            min_mask
);
  // strict compares keep the lowest index on ties
  always_comb begin
    t_max    = t_in[0];
    t_min    = t_in[0];
    max_mask = leg_mask_t'(1);
    min_mask = leg_mask_t'(1);
    for (int i = 1; i < LEGS; i++) begin
      if (t_in[i] > t_max) begin
        t_max    = t_in[i];
        max_mask = leg_mask_t'(1) << i;
      end
      if (t_in[i] < t_min) begin
        t_min    = t_in[i];
        min_mask = leg_mask_t'(1) << i;
      end
    end
  end
endmodule

// File: rtl/cgt_offset.sv
module cgt_offset #(
  parameter int TW = 16,
  parameter int PW = 15,
  parameter int IW = TW + 2
) (
  input  logic signed [TW-1:0] t_max,
  input  logic signed [TW-1:0] t_min,
  input  logic        [PW-1:0] period,
  output logic signed [IW-1:0] shift,
  output logic                 hi_rail
);
  logic signed [IW-1:0] mx, mn, per_x, rail_sum;

  always_comb begin
    mx       = IW'(t_max);
    mn       = IW'(t_min);
    per_x    = IW'({1'b0, period});
    rail_sum = mx + mn;
    hi_rail  = !rail_sum[IW-1];
    shift    = hi_rail ? (per_x - mx) : -mn;
  end
endmodule

// File: rtl/cgt_leg_sat.sv
module cgt_leg_sat #(
  parameter int TW = 16,
  parameter int PW = 15,
  parameter int IW = TW + 2
) (
  input  logic signed [TW-1:0] t_leg,
  input  logic signed [IW-1:0] shift,
  input  logic        [PW-1:0] period,
  output logic        [PW-1:0] gate
);
  logic signed [IW-1:0] moved, per_x;

  always_comb begin
    moved = IW'(t_leg) + shift;
    per_x = IW'({1'b0, period});
    if (moved[IW-1])        gate = '0;
    else if (moved > per_x) gate = period;
    else                    gate = moved[PW-1:0];
  end
endmodule

// File: rtl/clamp_gate_timer.sv
module clamp_gate_timer
  import cgt_pkg::*;
#(
  parameter int TW = 16,
  parameter int PW = TW - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [TW-1:0] t_a,
  input  logic signed [TW-1:0] t_b,
  input  logic signed [TW-1:0] t_c,
  input  logic        [PW-1:0] period,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic        [PW-1:0] g_a,
  output logic        [PW-1:0] g_b,
  output logic        [PW-1:0] g_c,
  output logic        [TW-1:0] eff_time,
  output logic        [LEGS-1:0] clamp_hi,
  output logic        [LEGS-1:0] clamp_lo
);
  localparam int IW = TW + 2;

  logic signed [TW-1:0] legs [LEGS];
  logic signed [TW-1:0] t_max, t_min;
  leg_mask_t            max_mask, min_mask;
  logic signed [IW-1:0] shift;
  logic                 hi_rail;
  logic        [PW-1:0] gate [LEGS];
  logic                 take;

  assign legs[0] = t_a;
  assign legs[1] = t_b;
  assign legs[2] = t_c;

  cgt_extremes #(.TW(TW)) u_ext (
    .t_in(legs), .t_max(t_max), .t_min(t_min),
    .max_mask(max_mask), .min_mask(min_mask)
  );

  cgt_offset #(.TW(TW), .PW(PW), .IW(IW)) u_off (
    .t_max(t_max), .t_min(t_min), .period(period),
    .shift(shift), .hi_rail(hi_rail)
  );

  for (genvar k = 0; k < LEGS; k++) begin : g_leg
    cgt_leg_sat #(.TW(TW), .PW(PW), .IW(IW)) u_sat (
      .t_leg(legs[k]), .shift(shift), .period(period), .gate(gate[k])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      g_a       <= '0;
      g_b       <= '0;
      g_c       <= '0;
      eff_time  <= '0;
      clamp_hi  <= '0;
      clamp_lo  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        g_a       <= gate[0];
        g_b       <= gate[1];
        g_c       <= gate[2];
        eff_time  <= TW'(t_max - t_min);
        clamp_hi  <= hi_rail ? max_mask : '0;
        clamp_lo  <= hi_rail ? '0 : min_mask;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clamp_gate_timer_sva.sv
module clamp_gate_timer_sva #(
  parameter int TW = 16,
  parameter int PW = TW - 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [PW-1:0] period,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] g_a,
  input logic [PW-1:0] g_b,
  input logic [PW-1:0] g_c,
  input logic [TW-1:0] eff_time,
  input logic [2:0]    clamp_hi,
  input logic [2:0]    clamp_lo
);
  logic [PW-1:0] per_cap;

  always_ff @(posedge clk) begin
    if (!rst_n)                      per_cap <= '0;
    else if (in_valid && in_ready)   per_cap <= period;
  end

  p_reset_idle_r9: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(g_a) && $stable(g_b)
      && $stable(g_c) && $stable(eff_time) && $stable(clamp_hi) && $stable(clamp_lo));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_one_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({clamp_hi, clamp_lo}) == 1);

  p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (g_a <= per_cap) && (g_b <= per_cap) && (g_c <= per_cap));

  p_high_rail_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!clamp_hi[0] || g_a == per_cap) && (!clamp_hi[1] || g_b == per_cap)
      && (!clamp_hi[2] || g_c == per_cap));

  p_low_rail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!clamp_lo[0] || g_a == '0) && (!clamp_lo[1] || g_b == '0)
      && (!clamp_lo[2] || g_c == '0));
endmodule

bind clamp_gate_timer clamp_gate_timer_sva #(.TW(TW), .PW(PW)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .period(period), .out_valid(out_valid), .out_ready(out_ready),
  .g_a(g_a), .g_b(g_b), .g_c(g_c), .eff_time(eff_time),
  .clamp_hi(clamp_hi), .clamp_lo(clamp_lo)
);

// File: tb/clamp_gate_timer_test.sv
`timescale 1ns/1ps
module clamp_gate_timer_test;
  localparam int TW = 16;
  localparam int PW = TW - 1;
  localparam int NV = 11;

  // stimulus: period, a, b, c ; expected: ga, gb, gc, eff, hi, lo
  localparam int VP [NV] = '{1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000, 1000, 200};
  localparam int VA [NV] = '{ 300, -400,  250,  100, -300,  800, -800, -100,  100,    0,  50};
  localparam int VB [NV] = '{-100,  100,    0,  100,   50, -700,  700,  -50, -500,    0, -30};
  localparam int VC [NV] = '{-200,  200, -250,  -50, -300,    0,    0,  400,   50,    0, -20};
  localparam int EA [NV] = '{1000,    0, 1000, 1000,    0, 1000,    0,  500,  600, 1000, 200};
  localparam int EB [NV] = '{ 600,  500,  750, 1000,  350,    0, 1000,  550,    0, 1000, 120};
  localparam int EC [NV] = '{ 500,  600,  500,  850,    0,  200,  800, 1000,  550, 1000, 130};
  localparam int EE [NV] = '{ 500,  600,  500,  150,  350, 1500, 1500,  500,  600,    0,  80};
  localparam int EH [NV] = '{   1,    0,    1,    1,    0,    1,    0,    4,    0,    1,   1};
  localparam int EL [NV] = '{   0,    1,    0,    0,    1,    0,    1,    0,    2,    0,   0};
  localparam string VR [NV] = '{"R1 R4", "R2 R4", "R3", "R6 R1", "R6 R2", "R4 R1",
                                "R4 R2", "R1 R7", "R2 R7", "R3 R6", "R4 R7"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic signed [TW-1:0] t_a = '0, t_b = '0, t_c = '0;
  logic [PW-1:0] period = '0;
  logic in_ready, out_valid;
  logic [PW-1:0] g_a, g_b, g_c;
  logic [TW-1:0] eff_time;
  logic [2:0] clamp_hi, clamp_lo;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  clamp_gate_timer #(.TW(TW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .t_a(t_a), .t_b(t_b), .t_c(t_c), .period(period),
    .out_valid(out_valid), .out_ready(out_ready),
    .g_a(g_a), .g_b(g_b), .g_c(g_c), .eff_time(eff_time),
    .clamp_hi(clamp_hi), .clamp_lo(clamp_lo)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 5000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic drive(int k);
    period = PW'(VP[k]);
    t_a    = TW'(VA[k]);
    t_b    = TW'(VB[k]);
    t_c    = TW'(VC[k]);
  endtask

  task automatic check_out(int k, string req);
    n_vec++;
    if (!out_valid || int'(g_a) != EA[k] || int'(g_b) != EB[k] || int'(g_c) != EC[k]
        || int'(eff_time) != EE[k] || int'(clamp_hi) != EH[k] || int'(clamp_lo) != EL[k]) begin
      n_bad++;
      $display("FAIL %s vec %0d: actual v=%0b g=%0d/%0d/%0d eff=%0d hi=%0d lo=%0d expected v=1 g=%0d/%0d/%0d eff=%0d hi=%0d lo=%0d",
               req, k, out_valid, g_a, g_b, g_c, eff_time, clamp_hi, clamp_lo,
               EA[k], EB[k], EC[k], EE[k], EH[k], EL[k]);
    end
  endtask

  task automatic check_bit(logic act, logic exp, string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check_bit(out_valid, 1'b0, "R9 out_valid in reset");
    check_bit(in_ready, 1'b1, "R10 in_ready when empty");
    rst_n = 1'b1;

    // table walk, one cycle latency (R8)
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(k);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_out(k, VR[k]);
    end
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R8 drained after take");

    // back-pressure: R8 hold, R10 stall
    out_ready = 1'b0;
    drive(1);
    in_valid = 1'b1;
    @(negedge clk);
    check_out(1, "R8 accepted under stall");
    drive(7);
    check_bit(in_ready, 1'b0, "R10 in_ready low while held");
    repeat (3) @(negedge clk);
    check_out(1, "R8 held while stalled");
    check_bit(in_ready, 1'b0, "R10 still stalled");
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(7, "R8 next taken on release");
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R8 empty after release");

    // reset mid-stream clears the output (R9)
    drive(0);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R9 reset drops held result");
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule